// File: doc/BRIEF.md
# CAN Receive FIFO Drain Reader

This block sits on the host side of a serial link to a CAN controller and empties that controller's receive FIFO. A single start pulse launches a drain: the block reads the controller's status register, and as long as the status reports frames waiting it reads one frame, unpacks it and hands it on. It then goes back to the status register. The drain ends when the status reports an empty FIFO, and the block returns to idle.

Every byte moves through a generic byte-wide SPI master handshake. The block holds a request with the byte to send until the master acknowledges the byte with a one-cycle pulse that carries the byte received. The block drives chip select itself, so each register read and each frame read is its own select window. A frame read returns a fixed-length image. The block keeps that image in a small buffer and decodes it according to the tag byte. The decoded frame appears on the outputs with a one-cycle valid pulse, and a running count of delivered frames is kept.

Top module: `can_rx_fifo_reader`

## Requirements
- R1: While reset is held, `cs_n` is 1, `xfer_req` is 0, `busy` is 0, `frm_valid` is 0 and `frm_count` is 0.
- R2: A `start` pulse in idle raises `busy` and opens a status window of exactly two byte transfers. The first byte sent is 0xE2 and the second is 0x00. The second byte received is the status value.
- R3: If status bit 1 (receive FIFO empty, mask 0x02) is clear, a frame read follows. If it is set, the drain ends and `busy` falls with no frame read. All other status bits are ignored.
- R4: A frame read is one select window of exactly 15 byte transfers. The first byte sent is 0x48 and the rest are 0x00. The first byte received is dropped, and received bytes 2 to 15 become frame image bytes b0 to b13.
- R5: `cs_n` goes high for at least one cycle between any two windows, and is high whenever `frm_valid` is 1. Once raised, `xfer_req` stays high until `xfer_ack` is seen.
- R6: Bit 7 of b0 selects an extended frame (`frm_ext`=1). The extended id is {b1, b2[7:5], b2[2:0], b3, b4[7:1]}. The standard id is {b1, b2[7:5]}, and id bits 28:11 are then 0. All other b0 bits are ignored.
- R7: `frm_dlc` is b5[3:0], limited to 8 when that value is above 8. b5[7:4] is ignored.
- R8: `frm_rtr` is b4[0]. For a remote frame, `frm_data` is all zero. Otherwise `frm_data[8i+7:8i]` is b(6+i) for i below `frm_dlc`, and zero for i at or above it.
- R9: Each frame read yields exactly one `frm_valid` pulse one cycle long, with the decoded fields. `frm_count` shows the count before that frame and goes up by one (modulo 2^CNT_W) on the next cycle. It never changes otherwise.
- R10: A `start` pulse while `busy` is 1 is ignored. It neither adds a status read nor restarts the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a drain (ignored while busy) |
| busy | output | 1 | Drain in progress |
| cs_n | output | 1 | Controller chip select, active low |
| xfer_req | output | 1 | Byte transfer request to the SPI master |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | One-cycle pulse: byte transfer finished |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |
| frm_valid | output | 1 | One-cycle pulse: decoded frame on outputs |
| frm_ext | output | 1 | Extended identifier flag |
| frm_rtr | output | 1 | Remote frame flag |
| frm_id | output | 29 | Identifier, right-aligned |
| frm_dlc | output | 4 | Data length, 0 to 8 |
| frm_data | output | 64 | Data bytes, byte i at bits 8i+7:8i |
| frm_count | output | CNT_W | Frames delivered, wrapping |

## Verification
Frame delivery and a new start request can fall in the same cycle. The delivery cycle doubles as the select gap before the next status read, so a start that arrives during it could restart the drain or add a status window. The bench toggles `start` on every cycle of a busy drain, which includes the `frm_valid` cycles. It then compares the number of status windows the controller model saw with the number of frames plus one, and checks each frame against the scoreboard in order.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int FRAME_BYTES = 14;
  localparam int ID_W        = 29;
  localparam int STD_ID_W    = 11;
  localparam int DATA_BYTES  = 8;
  localparam int DATA_W      = DATA_BYTES * 8;
  localparam int DLC_W       = 4;

  localparam logic [7:0] CMD_STATUS = 8'hE2;
  localparam logic [7:0] CMD_FIFO   = 8'h48;
  localparam logic [7:0] FILL_BYTE  = 8'h00;
  localparam int         EMPTY_BIT  = 1;

  // positions inside the frame image that the decoder depends on
  localparam int POS_TAG  = 0;
  localparam int POS_ID   = 1;
  localparam int POS_RTR  = 4;
  localparam int POS_DLC  = 5;
  localparam int POS_DATA = 6;

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_STAT,
    RD_SGAP,
    RD_FRAME,
    RD_DELIV
  } rd_state_t;

  typedef struct packed {
    logic              ext;
    logic              rtr;
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } rx_frame_t;
endpackage

// File: rtl/rxr_seq.sv
module rxr_seq
  import rxr_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  input  logic                                    xfer_ack,
  input  logic                                    stat_empty_bit,
  output logic                                    xfer_req,
  output logic [7:0]                              xfer_tx,
  output logic                                    cs_n,
  output logic                                    busy,
  output logic                                    buf_we,
  output logic [$clog2(FRAME_BYTES+1)-1:0]        buf_idx,
  output logic                                    deliver
);
  localparam int IW = $clog2(FRAME_BYTES + 1);
  localparam logic [IW-1:0] STAT_LAST  = IW'(1);
  localparam logic [IW-1:0] FRAME_LAST = IW'(FRAME_BYTES);

  rd_state_t     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          empty_q, empty_d;
  logic          empty_en;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    empty_en = 1'b0;
    empty_d  = empty_q;
    unique case (state_q)
      RD_IDLE: begin
        if (start) begin
          state_d = RD_STAT;
          idx_d   = '0;
        end
      end
      RD_STAT: begin
        if (xfer_ack) begin
          if (idx_q == STAT_LAST) begin
            empty_en = 1'b1;
            empty_d  = stat_empty_bit;
            state_d  = RD_SGAP;
            idx_d    = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      RD_SGAP: begin
        idx_d   = '0;
        state_d = empty_q ? RD_IDLE : RD_FRAME;
      end
      RD_FRAME: begin
        if (xfer_ack) begin
          if (idx_q == FRAME_LAST) begin
            state_d = RD_DELIV;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      RD_DELIV: begin
        state_d = RD_STAT;
        idx_d   = '0;
      end
      default: begin
        state_d = RD_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        empty_q <= 1'b1;
    else if (empty_en) empty_q <= empty_d;
  end

  logic in_window;
  assign in_window = (state_q == RD_STAT) || (state_q == RD_FRAME);
  assign xfer_req  = in_window;
  assign cs_n      = !in_window;
  assign busy      = (state_q != RD_IDLE);
  assign deliver   = (state_q == RD_DELIV);

  always_comb begin
    if (idx_q != '0)              xfer_tx = FILL_BYTE;
    else if (state_q == RD_FRAME) xfer_tx = CMD_FIFO;
    else                          xfer_tx = CMD_STATUS;
  end

  assign buf_we  = (state_q == RD_FRAME) && xfer_ack && (idx_q != '0);
  assign buf_idx = IW'(idx_q - 1'b1);
endmodule

// File: rtl/rxr_buf.sv
module rxr_buf
  import rxr_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [$clog2(FRAME_BYTES+1)-1:0]    idx,
  input  logic [7:0]                          din,
  output logic [FRAME_BYTES*8-1:0]            image
);
  localparam int IW = $clog2(FRAME_BYTES + 1);

  for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_byte
    logic       en;
    logic [7:0] q;
    assign en = we && (idx == IW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= din;
    end
    assign image[8*k +: 8] = q;
  end
endmodule

// File: rtl/rxr_unpack.sv
module rxr_unpack
  import rxr_pkg::*;
(
  input  logic [FRAME_BYTES*8-1:0] image,
  output rx_frame_t                frame
);
  logic [7:0] b [FRAME_BYTES];
  for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_split
    assign b[k] = image[8*k +: 8];
  end

  logic             ext_w, rtr_w;
  logic [DLC_W-1:0] raw_dlc, dlc_w;
  logic [ID_W-1:0]  id_w;
  logic [DATA_W-1:0] data_w;

  assign ext_w   = b[POS_TAG][7];
  assign rtr_w   = b[POS_RTR][0];
  assign raw_dlc = b[POS_DLC][DLC_W-1:0];
  assign dlc_w   = (raw_dlc > DLC_W'(DATA_BYTES)) ? DLC_W'(DATA_BYTES) : raw_dlc;

  always_comb begin
    if (ext_w)
      id_w = {b[POS_ID], b[POS_ID+1][7:5], b[POS_ID+1][2:0],
              b[POS_ID+2], b[POS_ID+3][7:1]};
    else
      id_w = {{(ID_W-STD_ID_W){1'b0}}, b[POS_ID], b[POS_ID+1][7:5]};
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_data
    assign data_w[8*i +: 8] = (!rtr_w && (dlc_w > DLC_W'(i))) ? b[POS_DATA+i] : 8'h00;
  end

  assign frame = '{ext: ext_w, rtr: rtr_w, id: id_w, dlc: dlc_w, data: data_w};

  logic unused_bits;
  assign unused_bits = ^{b[POS_TAG][6:0], b[POS_ID+1][4:3], b[POS_DLC][7:DLC_W]};
endmodule

// File: rtl/can_rx_fifo_reader.sv
module can_rx_fifo_reader
  import rxr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              cs_n,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              frm_valid,
  output logic              frm_ext,
  output logic              frm_rtr,
  output logic [28:0]       frm_id,
  output logic [3:0]        frm_dlc,
  output logic [63:0]       frm_data,
  output logic [CNT_W-1:0]  frm_count
);
  localparam int IW = $clog2(FRAME_BYTES + 1);

  logic                     buf_we;
  logic [IW-1:0]            buf_idx;
  logic                     deliver;
  logic [FRAME_BYTES*8-1:0] image;
  rx_frame_t                frame;

  rxr_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .xfer_ack       (xfer_ack),
    .stat_empty_bit (xfer_rx[EMPTY_BIT]),
    .xfer_req       (xfer_req),
    .xfer_tx        (xfer_tx),
    .cs_n           (cs_n),
    .busy           (busy),
    .buf_we         (buf_we),
    .buf_idx        (buf_idx),
    .deliver        (deliver)
  );

  rxr_buf u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (buf_we),
    .idx   (buf_idx),
    .din   (xfer_rx),
    .image (image)
  );

  rxr_unpack u_unpack (
    .image (image),
    .frame (frame)
  );

  logic [CNT_W-1:0] cnt_q, cnt_d;
  always_comb begin
    cnt_d = cnt_q;
    if (deliver) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign frm_valid = deliver;
  assign frm_ext   = frame.ext;
  assign frm_rtr   = frame.rtr;
  assign frm_id    = frame.id;
  assign frm_dlc   = frame.dlc;
  assign frm_data  = frame.data;
  assign frm_count = cnt_q;
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             cs_n,
  input logic             xfer_req,
  input logic             xfer_ack,
  input logic             frm_valid,
  input logic             frm_ext,
  input logic             frm_rtr,
  input logic [28:0]      frm_id,
  input logic [3:0]       frm_dlc,
  input logic [63:0]      frm_data,
  input logic [CNT_W-1:0] frm_count
);
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !cs_n)); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> xfer_req); // R5

  AST_CS_HIGH_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> cs_n); // R5

  AST_STD_ID_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ext) |-> (frm_id[28:11] == 18'd0)); // R6

  AST_DLC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_dlc <= 4'd8)); // R7

  AST_REMOTE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_rtr) |-> (frm_data == 64'd0)); // R8

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (frm_count == CNT_W'($past(frm_count) + 1'b1))); // R9

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> $stable(frm_count)); // R9
endmodule

bind can_rx_fifo_reader rxr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .cs_n      (cs_n),
  .xfer_req  (xfer_req),
  .xfer_ack  (xfer_ack),
  .frm_valid (frm_valid),
  .frm_ext   (frm_ext),
  .frm_rtr   (frm_rtr),
  .frm_id    (frm_id),
  .frm_dlc   (frm_dlc),
  .frm_data  (frm_data),
  .frm_count (frm_count)
);

// File: tb/sim_can_rx_fifo_reader.sv
`timescale 1ns/1ps
module sim_can_rx_fifo_reader;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             busy, cs_n, xfer_req;
  logic [7:0]       xfer_tx;
  logic             xfer_ack = 1'b0;
  logic [7:0]       xfer_rx = 8'h00;
  logic             frm_valid, frm_ext, frm_rtr;
  logic [28:0]      frm_id;
  logic [3:0]       frm_dlc;
  logic [63:0]      frm_data;
  logic [CNT_W-1:0] frm_count;

  always #10 clk = ~clk;

  can_rx_fifo_reader #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cs_n(cs_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_id(frm_id),
    .frm_dlc(frm_dlc), .frm_data(frm_data), .frm_count(frm_count)
  );

  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [28:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
  } exp_t;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  exp_t exp_q[$];
  logic [7:0] ctl_fifo[$];
  int   lat = 0;
  int   wait_cnt = 0;
  int   win_cnt = 0;
  logic [7:0] win_cmd = 8'h00;
  bit   bad_fill = 0;
  int   n_stat = 0;
  int   n_frd = 0;
  logic [CNT_W-1:0] exp_cnt = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: encode one frame image for the controller model and queue the expected result
  task automatic push_frame(input bit ext, input logic [28:0] id, input bit rtr,
                            input logic [3:0] raw_dlc, input logic [63:0] data);
    logic [7:0] img [14];
    exp_t e;
    int   n;
    img[0] = ext ? 8'h85 : 8'h05;
    if (ext) begin
      img[1] = id[28:21];
      img[2] = {id[20:18], 2'b11, id[17:15]};
      img[3] = id[14:7];
      img[4] = {id[6:0], rtr};
    end else begin
      img[1] = id[10:3];
      img[2] = {id[2:0], 5'b10101};
      img[3] = 8'h3C;
      img[4] = {7'h55, rtr};
    end
    img[5] = {4'hA, raw_dlc};
    for (int i = 0; i < 8; i++) img[6+i] = data[8*i +: 8];
    for (int i = 0; i < 14; i++) ctl_fifo.push_back(img[i]);
    n = (raw_dlc > 4'd8) ? 8 : int'(raw_dlc);
    e.ext  = ext;
    e.rtr  = rtr;
    e.id   = ext ? id : {18'd0, id[10:0]};
    e.dlc  = 4'(n);
    e.data = '0;
    for (int i = 0; i < 8; i++)
      if (!rtr && i < n) e.data[8*i +: 8] = data[8*i +: 8];
    exp_q.push_back(e);
  endtask

  // controller model on the SPI master handshake
  always @(negedge clk) begin
    xfer_ack = 1'b0;
    if (cs_n) begin
      if (win_cnt != 0) begin
        if (win_cmd == 8'hE2)
          check(win_cnt == 2, "R2", "status window length", 64'(win_cnt), 64'd2);
        else
          check(win_cnt == 15, "R4", "frame window length", 64'(win_cnt), 64'd15);
        check(!bad_fill, "R4", "fill bytes zero", 64'(bad_fill), 64'd0);
      end
      win_cnt  = 0;
      wait_cnt = 0;
      bad_fill = 0;
    end else if (xfer_req) begin
      if (wait_cnt < lat) begin
        wait_cnt++;
      end else begin
        wait_cnt = 0;
        if (win_cnt == 0) begin
          win_cmd = xfer_tx;
          if (xfer_tx == 8'hE2) n_stat++;
          else if (xfer_tx == 8'h48) n_frd++;
          xfer_rx = 8'hA5;
        end else begin
          if (xfer_tx != 8'h00) bad_fill = 1;
          if (win_cmd == 8'hE2)
            xfer_rx = (ctl_fifo.size() == 0) ? 8'h82 : 8'h7D;
          else
            xfer_rx = (ctl_fifo.size() != 0) ? ctl_fifo.pop_front() : 8'hEE;
        end
        win_cnt++;
        xfer_ack = 1'b1;
      end
    end
  end

  // monitor: compare each delivered frame against the scoreboard
  always @(negedge clk) begin
    if (rst_n && frm_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected frame", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(frm_ext == e.ext, "R6", "ext flag", 64'(frm_ext), 64'(e.ext));
        check(frm_id == e.id, "R6", "identifier", 64'(frm_id), 64'(e.id));
        check(frm_dlc == e.dlc, "R7", "dlc", 64'(frm_dlc), 64'(e.dlc));
        check(frm_rtr == e.rtr, "R8", "remote flag", 64'(frm_rtr), 64'(e.rtr));
        check(frm_data == e.data, "R8", "data", frm_data, e.data);
        check(frm_count == exp_cnt, "R9", "count before step", 64'(frm_count), 64'(exp_cnt));
      end
      exp_cnt = exp_cnt + 1'b1;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_sim();
    end
  end

  initial begin
    int s0, f0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cs_n == 1'b1, "R1", "cs_n in reset", 64'(cs_n), 64'd1);
    check(xfer_req == 1'b0, "R1", "req in reset", 64'(xfer_req), 64'd0);
    check(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'd0);
    check(frm_valid == 1'b0, "R1", "valid in reset", 64'(frm_valid), 64'd0);
    check(frm_count == '0, "R1", "count in reset", 64'(frm_count), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: empty FIFO, one status read and no frame read
    s0 = n_stat; f0 = n_frd;
    pulse_start();
    check(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
    wait_idle();
    check(n_stat - s0 == 1, "R3", "status reads on empty", 64'(n_stat - s0), 64'd1);
    check(n_frd - f0 == 0, "R3", "frame reads on empty", 64'(n_frd - f0), 64'd0);
    check(frm_count == 0, "R9", "count after empty drain", 64'(frm_count), 64'd0);

    // mixed frames, no latency
    push_frame(1'b0, 29'h0000_05A3, 1'b0, 4'd3, 64'h8877_6655_4433_2211);
    push_frame(1'b1, 29'h1234_5678, 1'b1, 4'd5, 64'hFFEE_DDCC_BBAA_9988);
    push_frame(1'b1, 29'h0ABC_DEF1, 1'b0, 4'd12, 64'h0102_0304_0506_0708);
    s0 = n_stat; f0 = n_frd;
    pulse_start();
    wait_idle();
    check(n_frd - f0 == 3, "R4", "frame reads", 64'(n_frd - f0), 64'd3);
    check(n_stat - s0 == 4, "R3", "status reads", 64'(n_stat - s0), 64'd4);
    check(frm_count == 3, "R9", "count after three", 64'(frm_count), 64'd3);

    // R10: start toggled during the whole drain, including delivery cycles
    push_frame(1'b0, 29'h0000_07FF, 1'b0, 4'd8, 64'hDEAD_BEEF_CAFE_F00D);
    push_frame(1'b0, 29'h0000_0000, 1'b1, 4'd0, 64'h1111_2222_3333_4444);
    s0 = n_stat; f0 = n_frd;
    pulse_start();
    while (busy) begin
      start = ~start;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R10", "idle after busy starts", 64'(busy), 64'd0);
    check(n_stat - s0 == 3, "R10", "status reads with busy starts", 64'(n_stat - s0), 64'd3);
    check(n_frd - f0 == 2, "R10", "frame reads with busy starts", 64'(n_frd - f0), 64'd2);

    // slow master, extreme identifiers and lengths
    lat = 2;
    push_frame(1'b1, 29'h1FFF_FFFF, 1'b0, 4'd0, 64'hAAAA_AAAA_AAAA_AAAA);
    push_frame(1'b1, 29'h0000_0000, 1'b0, 4'd15, 64'h0F0E_0D0C_0B0A_0908);
    push_frame(1'b0, 29'h0000_0400, 1'b0, 4'd9, 64'h1357_9BDF_2468_ACE0);
    push_frame(1'b0, 29'h0000_0001, 1'b0, 4'd1, 64'h7766_5544_3322_11FF);
    pulse_start();
    wait_idle();
    lat = 1;
    push_frame(1'b1, 29'h1555_5555, 1'b1, 4'd8, 64'h5A5A_5A5A_5A5A_5A5A);
    pulse_start();
    wait_idle();
    check(frm_count == 10, "R9", "final count", 64'(frm_count), 64'd10);
    check(exp_q.size() == 0, "R9", "scoreboard drained", 64'(exp_q.size()), 64'd0);
    check(ctl_fifo.size() == 0, "R4", "controller FIFO drained", 64'(ctl_fifo.size()), 64'd0);
    finish_sim();
  end
endmodule